// File: doc/BRIEF.md
# DMA Window Descriptor Checker

This block guards a single linear DMA window described by a 16-byte descriptor. In normal operation a descriptor is loaded once. A stream of access requests (a byte offset and a read/write flag) is then checked against it. Each accepted request returns, one cycle later, either the physical byte address or a two-bit fault code. A window is refused when the offset runs past the limit, when the direction is not allowed by the access mode, or when the window's target is not a plain linear one.

The block also has a second path that checks a proposed descriptor before it is built. The path is given a class code, an access mode, a target, an offset and a size. It checks these against the allowed codes and against the size limit of the chosen target, using arithmetic that cannot wrap. When all checks pass, it packs the descriptor words that the translation path consumes. The fourth descriptor word duplicates the third, so the load port carries only words 0 to 2.

Top module: `dma_window_checker`

## Requirements
- R1: After reset, rsp_valid and bld_done are 0 and the stored descriptor is all zero, so a request made before any load returns fault 11.
- R2: An accepted request with no fault returns fault 00 and address {desc_word2[31:12],12'h000} + desc_word0[31:20] + offset, modulo 2^32.
- R3: A request whose offset exceeds desc_word1 (the limit) returns fault 01 and address 0.
- R4: The access mode in desc_word0[15:14] uses 0 for read-write, 1 for read-only, 2 for write-only and 3 for invalid. A write under mode 1, a read under mode 2, or any request under mode 3 returns fault 10 and address 0.
- R5: When desc_word0[17:16] is 1 (tiled) or desc_word0[13] (linear) is 0, every request returns fault 11. This check takes priority over the range check, and the range check takes priority over the access check.
- R6: req_ready is 0 in any cycle where desc_load is 1, so a request in that cycle is not accepted. The new descriptor governs requests from the next cycle on.
- R7: A build request is refused with fault 10 when bld_class is not 12'h03D, 12'h002 or 12'h003, or when bld_access is 3. The class is checked first.
- R8: bld_target 0 (video memory) and 3 (AGP) are accepted. Targets 1 and 2 are refused with fault 11, unless a class or access fault already applies.
- R9: A build whose offset exceeds the target limit (vram_limit or agp_limit), or whose offset+size exceeds it, is refused with fault 01. The sum is formed in 33 bits, so it cannot wrap.
- R10: A passing build returns fault 00 with the following words. Word0 = {phys[11:0], 2'b00, target, access, 1'b1, 1'b1, class}. Word1 = size-1. Word2 = word3 = {phys[31:12], 10'b0, writable, 1'b0}, where writable is 1 for access 0 or 2. A refused build returns all words as zero.
- R11: For target 3, phys is offset + agp_base modulo 2^32. For target 0, phys is the offset itself.
- R12: rsp_valid is a one-cycle pulse in the cycle after a request handshake, and bld_done is a one-cycle pulse in the cycle after bld_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_load | input | 1 | Capture descriptor words this cycle |
| desc_word0 | input | 32 | Adjust, target, mode, flags, class |
| desc_word1 | input | 32 | Window limit (size minus one) |
| desc_word2 | input | 32 | Page frame and write flag |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted |
| req_offset | input | 32 | Byte offset into the window |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 range, 10 access, 11 target |
| bld_valid | input | 1 | Build check request |
| bld_class | input | 12 | Requested class code |
| bld_access | input | 2 | Requested access mode |
| bld_target | input | 2 | Requested target |
| bld_offset | input | 32 | Requested window offset |
| bld_size | input | 32 | Requested window size |
| vram_limit | input | 32 | Size limit for video memory |
| agp_limit | input | 32 | Size limit for AGP |
| agp_base | input | 32 | AGP aperture base address |
| bld_done | output | 1 | Build result present |
| bld_fault | output | 2 | Build fault code |
| bld_word0 | output | 32 | Packed word 0 |
| bld_word1 | output | 32 | Packed word 1 |
| bld_word2 | output | 32 | Packed word 2 |
| bld_word3 | output | 32 | Packed word 3 |

## Verification
The translation path is tested with hand-built descriptors that cover every mode and target. These include offsets exactly at the limit and one past it, and descriptors where two faults apply at once, which shows the order in which faults take priority. A base near the top of the address space shows that the address addition wraps. The build path is tested with each legal and illegal class, access and target. The range cases place offset+size exactly at the limit and one above it, and one case wraps past 2^32, which separates a 33-bit check from a 32-bit one. An AGP case shows that the aperture base is added before the address is split. A load issued in the same cycle as a request shows the stall and the point at which the new descriptor takes effect. Randomised descriptors and requests then mix all of these cases under the per-cycle reference model.

// File: rtl/dwc_pkg.sv
// Shared types and field positions for the DMA window checker.
// Assumes 32-bit addresses split into a 20-bit frame and a 12-bit in-page adjust.
package dwc_pkg;
    localparam int ADDR_W  = 32;
    localparam int PAGE_W  = 12;
    localparam int FRAME_W = ADDR_W - PAGE_W;
    localparam int CLASS_W = 12;

    // Bit positions in descriptor word 0 that the translator decodes
    localparam int W0_LINEAR = 13;
    localparam int W0_PTP    = 12;
    localparam int W0_MODE   = 14;
    localparam int W0_TGT    = 16;
    localparam int W0_ADJ    = 20;
    localparam int W2_WRITE  = 1;

    typedef enum logic [1:0] {
        FLT_OK     = 2'd0,
        FLT_RANGE  = 2'd1,
        FLT_ACCESS = 2'd2,
        FLT_TARGET = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        MODE_RW  = 2'd0,
        MODE_RO  = 2'd1,
        MODE_WO  = 2'd2,
        MODE_BAD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_TILED = 2'd1,
        TGT_PCI   = 2'd2,
        TGT_AGP   = 2'd3
    } target_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [PAGE_W-1:0]  adjust;
        logic [ADDR_W-1:0]  limit;
        mode_e              mode;
        target_e            target;
        logic               linear;
    } desc_t;
endpackage

// File: rtl/dwc_desc_store.sv
// Holds the active window descriptor and decodes its fields.
// Assumes word 3 duplicates word 2 and is therefore not carried; the
// page-table-present flag and the word-2 write flag are informational only.
module dwc_desc_store
    import dwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] word0,
    input  logic [ADDR_W-1:0] word1,
    input  logic [ADDR_W-1:0] word2,
    output desc_t             desc
);
    desc_t desc_q;
    logic  unused_bits;

    // Bits that no consumer decodes
    assign unused_bits = ^{word0[W0_ADJ-1:W0_TGT+2], word0[W0_PTP],
                           word0[CLASS_W-1:0], word2[PAGE_W-1:0]};

    // Capture and decode the descriptor on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (load) begin
            desc_q.frame  <= word2[ADDR_W-1:PAGE_W];
            desc_q.adjust <= word0[W0_ADJ +: PAGE_W];
            desc_q.limit  <= word1;
            desc_q.mode   <= mode_e'(word0[W0_MODE +: 2]);
            desc_q.target <= target_e'(word0[W0_TGT +: 2]);
            desc_q.linear <= word0[W0_LINEAR];
        end
    end

    assign desc = desc_q;
endmodule

// File: rtl/dwc_translate.sv
// Checks one access request per cycle against the active descriptor and
// returns a registered physical address or fault code one cycle later.
// Assumes the caller gates acceptance through req_ready.
module dwc_translate
    import dwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  desc_t             desc,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_fault
);
    logic              accept;
    logic              tgt_ok;
    logic              over;
    logic              dir_bad;
    fault_e            fault_c;
    logic [ADDR_W-1:0] addr_c;

    assign accept = req_valid && req_ready;

    // Fault classification in priority order: target, range, direction
    always_comb begin
        tgt_ok  = desc.linear && (desc.target != TGT_TILED);
        over    = req_offset > desc.limit;
        dir_bad = (desc.mode == MODE_BAD)
               || (req_write  && desc.mode == MODE_RO)
               || (!req_write && desc.mode == MODE_WO);
        if (!tgt_ok)      fault_c = FLT_TARGET;
        else if (over)    fault_c = FLT_RANGE;
        else if (dir_bad) fault_c = FLT_ACCESS;
        else              fault_c = FLT_OK;
    end

    // Physical address: page frame plus in-page adjust plus offset
    always_comb begin
        addr_c = {desc.frame, {PAGE_W{1'b0}}} + ADDR_W'(desc.adjust) + req_offset;
    end

    // Register the response for one cycle after the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= FLT_OK;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_fault <= fault_c;
                rsp_addr  <= (fault_c == FLT_OK) ? addr_c : '0;
            end
        end
    end

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    // R12
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    // R3
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && desc.linear && desc.target != TGT_TILED && req_offset > desc.limit)
        |=> (rsp_fault == FLT_RANGE && rsp_addr == '0));
    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && desc.linear && desc.target != TGT_TILED && req_offset <= desc.limit
         && req_write && desc.mode == MODE_RO) |=> (rsp_fault == FLT_ACCESS));
endmodule

// File: rtl/dwc_build.sv
// Validates a proposed DMA window against class, mode, target and size
// limits and packs the descriptor words; result registered one cycle later.
// Assumes limits are window sizes in bytes; sums are formed in ADDR_W+1 bits.
module dwc_build
    import dwc_pkg::*;
#(
    parameter logic [CLASS_W-1:0] CLS_LOCAL = 12'h03D,
    parameter logic [CLASS_W-1:0] CLS_READ  = 12'h002,
    parameter logic [CLASS_W-1:0] CLS_WRITE = 12'h003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bld_valid,
    input  logic [CLASS_W-1:0] bld_class,
    input  logic [1:0]         bld_access,
    input  logic [1:0]         bld_target,
    input  logic [ADDR_W-1:0]  bld_offset,
    input  logic [ADDR_W-1:0]  bld_size,
    input  logic [ADDR_W-1:0]  vram_limit,
    input  logic [ADDR_W-1:0]  agp_limit,
    input  logic [ADDR_W-1:0]  agp_base,
    output logic               bld_done,
    output logic [1:0]         bld_fault,
    output logic [3:0][ADDR_W-1:0] bld_words
);
    localparam int NWORDS = 4;

    logic                  cls_ok;
    logic                  mode_ok;
    logic                  tgt_ok;
    logic [ADDR_W-1:0]     lim;
    logic [ADDR_W:0]       end_sum;
    logic                  rng_bad;
    fault_e                fault_c;
    logic [ADDR_W-1:0]     phys;
    logic                  writable;
    logic [NWORDS-1:0][ADDR_W-1:0] packed_c;

    // Legality checks in priority order: class, mode, target, range
    always_comb begin
        cls_ok  = (bld_class == CLS_LOCAL) || (bld_class == CLS_READ)
               || (bld_class == CLS_WRITE);
        mode_ok = bld_access != MODE_BAD;
        tgt_ok  = (bld_target == TGT_VRAM) || (bld_target == TGT_AGP);
        lim     = (bld_target == TGT_AGP) ? agp_limit : vram_limit;
        end_sum = {1'b0, bld_offset} + {1'b0, bld_size};
        rng_bad = ({1'b0, bld_offset} > {1'b0, lim}) || (end_sum > {1'b0, lim});
        if (!cls_ok || !mode_ok) fault_c = FLT_ACCESS;
        else if (!tgt_ok)        fault_c = FLT_TARGET;
        else if (rng_bad)        fault_c = FLT_RANGE;
        else                     fault_c = FLT_OK;
    end

    // Physical base: aperture base added for AGP before the split
    always_comb begin
        phys     = (bld_target == TGT_AGP) ? bld_offset + agp_base : bld_offset;
        writable = bld_access != MODE_RO;
    end

    // Word 0 carries adjust, target, mode, the two fixed flags and the class
    assign packed_c[0] = {phys[PAGE_W-1:0], 2'b00, bld_target, bld_access,
                          1'b1, 1'b1, bld_class};
    // Word 1 is the inclusive limit
    assign packed_c[1] = bld_size - 1'b1;

    // Words 2 and 3 repeat the frame with the write flag
    for (genvar g = 2; g < NWORDS; g++) begin : g_frame_word
        assign packed_c[g] = {phys[ADDR_W-1:PAGE_W], {(PAGE_W-W2_WRITE-1){1'b0}},
                              writable, {W2_WRITE{1'b0}}};
    end

    // Register the verdict and the packed words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bld_done  <= 1'b0;
            bld_fault <= FLT_OK;
            bld_words <= '0;
        end else begin
            bld_done <= bld_valid;
            if (bld_valid) begin
                bld_fault <= fault_c;
                bld_words <= (fault_c == FLT_OK) ? packed_c : '0;
            end
        end
    end

    // R8
    bad_target_build_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_valid && cls_ok && mode_ok && !tgt_ok) |=> (bld_fault == FLT_TARGET));
    // R9
    wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_valid && cls_ok && mode_ok && tgt_ok && end_sum[ADDR_W])
        |=> (bld_fault == FLT_RANGE));
    // R10
    pack_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_done && bld_fault == FLT_OK)
        |-> (bld_words[0][W0_LINEAR] && bld_words[0][W0_PTP] && bld_words[2] == bld_words[3]));
    // R10
    refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_done && bld_fault != FLT_OK) |-> (bld_words == '0));
endmodule

// File: rtl/dma_window_checker.sv
// Top level: descriptor store, request translator and build checker.
// Assumes a descriptor load stalls the request port for that cycle so a
// request never sees a half-updated window.
module dma_window_checker
    import dwc_pkg::*;
#(
    parameter logic [CLASS_W-1:0] CLS_LOCAL = 12'h03D,
    parameter logic [CLASS_W-1:0] CLS_READ  = 12'h002,
    parameter logic [CLASS_W-1:0] CLS_WRITE = 12'h003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_load,
    input  logic [ADDR_W-1:0]  desc_word0,
    input  logic [ADDR_W-1:0]  desc_word1,
    input  logic [ADDR_W-1:0]  desc_word2,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_offset,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [1:0]         rsp_fault,
    input  logic               bld_valid,
    input  logic [CLASS_W-1:0] bld_class,
    input  logic [1:0]         bld_access,
    input  logic [1:0]         bld_target,
    input  logic [ADDR_W-1:0]  bld_offset,
    input  logic [ADDR_W-1:0]  bld_size,
    input  logic [ADDR_W-1:0]  vram_limit,
    input  logic [ADDR_W-1:0]  agp_limit,
    input  logic [ADDR_W-1:0]  agp_base,
    output logic               bld_done,
    output logic [1:0]         bld_fault,
    output logic [ADDR_W-1:0]  bld_word0,
    output logic [ADDR_W-1:0]  bld_word1,
    output logic [ADDR_W-1:0]  bld_word2,
    output logic [ADDR_W-1:0]  bld_word3
);
    desc_t                  desc;
    logic [3:0][ADDR_W-1:0] words;

    // Stall requests while the window is being replaced
    assign req_ready = !desc_load;

    dwc_desc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (desc_load),
        .word0 (desc_word0),
        .word1 (desc_word1),
        .word2 (desc_word2),
        .desc  (desc)
    );

    dwc_translate u_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc       (desc),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_offset (req_offset),
        .req_write  (req_write),
        .rsp_valid  (rsp_valid),
        .rsp_addr   (rsp_addr),
        .rsp_fault  (rsp_fault)
    );

    dwc_build #(
        .CLS_LOCAL (CLS_LOCAL),
        .CLS_READ  (CLS_READ),
        .CLS_WRITE (CLS_WRITE)
    ) u_build (
        .clk        (clk),
        .rst_n      (rst_n),
        .bld_valid  (bld_valid),
        .bld_class  (bld_class),
        .bld_access (bld_access),
        .bld_target (bld_target),
        .bld_offset (bld_offset),
        .bld_size   (bld_size),
        .vram_limit (vram_limit),
        .agp_limit  (agp_limit),
        .agp_base   (agp_base),
        .bld_done   (bld_done),
        .bld_fault  (bld_fault),
        .bld_words  (words)
    );

    assign bld_word0 = words[0];
    assign bld_word1 = words[1];
    assign bld_word2 = words[2];
    assign bld_word3 = words[3];
endmodule

// File: tb/tb_dma_window_checker.sv
`timescale 1ns/1ps
module tb_dma_window_checker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        desc_load;
    logic [31:0] desc_word0, desc_word1, desc_word2;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_offset;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic        bld_valid;
    logic [11:0] bld_class;
    logic [1:0]  bld_access, bld_target;
    logic [31:0] bld_offset, bld_size, vram_limit, agp_limit, agp_base;
    logic        bld_done;
    logic [1:0]  bld_fault;
    logic [31:0] bld_word0, bld_word1, bld_word2, bld_word3;

    int total = 0;
    int bad   = 0;
    bit armed = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] md0 = 0, md1 = 0, md2 = 0;
    bit          fresh = 1;
    bit          exp_rv = 0, exp_bd = 0;
    logic [1:0]  exp_rf, exp_bf;
    logic [31:0] exp_ra, exp_w0, exp_w1, exp_w2;
    string       rtag, btag;

    always #2.5 clk = ~clk;

    dma_window_checker dut (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model of the translation verdict
    function automatic logic [1:0] m_fault(input logic [31:0] d0, d1, off, input bit wr);
        int mode = int'(d0[15:14]);
        if (d0[13] == 1'b0 || d0[17:16] == 2'd1) return 2'd3;
        if (longint'(off) > longint'(d1)) return 2'd1;
        if (mode == 3 || (wr && mode == 1) || (!wr && mode == 2)) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] m_addr(input logic [31:0] d0, d2, off);
        longint unsigned s;
        s = longint'(d2 / 4096) * 4096 + longint'(d0 / 1048576) + longint'(off);
        return 32'(s % 64'h1_0000_0000);
    endfunction

    // Model of the build verdict and packed words
    task automatic m_build(input logic [11:0] c, input logic [1:0] a, t,
                           input logic [31:0] off, sz,
                           output logic [1:0] f, output logic [31:0] w0, w1, w2);
        longint unsigned lim, ph;
        lim = (t == 2'd3) ? longint'(agp_limit) : longint'(vram_limit);
        if (!(c == 12'h03D || c == 12'h002 || c == 12'h003) || a == 2'd3) f = 2'd2;
        else if (t == 2'd1 || t == 2'd2) f = 2'd3;
        else if (longint'(off) > lim || longint'(off) + longint'(sz) > lim) f = 2'd1;
        else f = 2'd0;
        ph = (t == 2'd3) ? (longint'(off) + longint'(agp_base)) % 64'h1_0000_0000 : longint'(off);
        if (f == 2'd0) begin
            w0 = 32'((ph % 4096) * 1048576 + longint'(t) * 65536 + longint'(a) * 16384 + 12288 + longint'(c));
            w1 = 32'((longint'(sz) + 64'hFFFF_FFFF) % 64'h1_0000_0000);
            w2 = 32'((ph / 4096) * 4096 + ((a != 2'd1) ? 2 : 0));
        end else begin
            w0 = 0; w1 = 0; w2 = 0;
        end
    endtask

    function automatic string ftag(input logic [1:0] f);
        case (f)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Cycle model: predicts what the registers hold after this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rv = 0; exp_bd = 0; md0 = 0; md1 = 0; md2 = 0; fresh = 1;
        end else begin
            check(req_ready === !desc_load, "R6", "req_ready", {31'b0, req_ready}, {31'b0, !desc_load});
            exp_rv = req_valid && !desc_load;
            if (exp_rv) begin
                exp_rf = m_fault(md0, md1, req_offset, req_write);
                exp_ra = (exp_rf == 2'd0) ? m_addr(md0, md2, req_offset) : 32'h0;
                rtag   = fresh ? "R1" : ftag(exp_rf);
            end
            if (desc_load) begin
                md0 = desc_word0; md1 = desc_word1; md2 = desc_word2; fresh = 0;
            end
            exp_bd = bld_valid;
            if (bld_valid) begin
                m_build(bld_class, bld_access, bld_target, bld_offset, bld_size,
                        exp_bf, exp_w0, exp_w1, exp_w2);
                case (exp_bf)
                    2'd0: btag = (bld_target == 2'd3) ? "R11" : "R10";
                    2'd1: btag = "R9";
                    2'd2: btag = "R7";
                    default: btag = "R8";
                endcase
            end
            armed = 1;
        end
    end

    // Compare registered outputs away from the active edge
    always @(negedge clk) begin
        if (armed && rst_n) begin
            check(rsp_valid === exp_rv, "R12", "rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_rv});
            if (exp_rv) begin
                check(rsp_fault === exp_rf, rtag, "rsp_fault", {30'b0, rsp_fault}, {30'b0, exp_rf});
                check(rsp_addr === exp_ra, rtag, "rsp_addr", rsp_addr, exp_ra);
            end
            check(bld_done === exp_bd, "R12", "bld_done", {31'b0, bld_done}, {31'b0, exp_bd});
            if (exp_bd) begin
                check(bld_fault === exp_bf, btag, "bld_fault", {30'b0, bld_fault}, {30'b0, exp_bf});
                check(bld_word0 === exp_w0, btag, "bld_word0", bld_word0, exp_w0);
                check(bld_word1 === exp_w1, btag, "bld_word1", bld_word1, exp_w1);
                check(bld_word2 === exp_w2, btag, "bld_word2", bld_word2, exp_w2);
                check(bld_word3 === exp_w2, btag, "bld_word3", bld_word3, exp_w2);
            end
        end
    end

    task automatic tick;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] d0_of(input int adj, input int tgt, input int mode, input bit lin);
        return 32'(adj * 1048576 + tgt * 65536 + mode * 16384 + (lin ? 8192 : 0) + 4096 + 12'h03D);
    endfunction

    task automatic load(input logic [31:0] w0, w1, w2);
        desc_load = 1; desc_word0 = w0; desc_word1 = w1; desc_word2 = w2;
        tick;
        desc_load = 0;
    endtask

    task automatic req(input logic [31:0] off, input bit wr);
        req_valid = 1; req_offset = off; req_write = wr;
        tick;
        req_valid = 0;
    endtask

    task automatic bld(input logic [11:0] c, input logic [1:0] a, t, input logic [31:0] off, sz);
        bld_valid = 1; bld_class = c; bld_access = a; bld_target = t;
        bld_offset = off; bld_size = sz;
        tick;
        bld_valid = 0;
    endtask

    // Watchdog
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; desc_load = 0; desc_word0 = 0; desc_word1 = 0; desc_word2 = 0;
        req_valid = 0; req_offset = 0; req_write = 0;
        bld_valid = 0; bld_class = 0; bld_access = 0; bld_target = 0;
        bld_offset = 0; bld_size = 0;
        vram_limit = 32'h0100_0000; agp_limit = 32'h0040_0000; agp_base = 32'hE000_0000;
        repeat (3) tick;
        rst_n = 1;
        @(negedge clk);
        // R1 reset state at the ports
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 0);
        check(bld_done === 1'b0, "R1", "bld_done after reset", {31'b0, bld_done}, 0);
        check(req_ready === 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 1);
        tick;
        req(32'h0, 0);                       // R1: no window yet -> fault 11
        tick;

        // R2/R3: read-write video window, base 0x12345678, limit 0xFFF
        load(d0_of(12'h678, 0, 0, 1), 32'h0000_0FFF, 32'h1234_5002);
        req(32'h0, 0);
        req(32'hFFF, 1);
        req(32'h1000, 0);
        req(32'hFFFF_FFFF, 1);
        // R4: read-only, write-only, invalid mode
        load(d0_of(0, 0, 1, 1), 32'h0000_FFFF, 32'h0800_0000);
        req(32'h10, 1);
        req(32'h10, 0);
        req(32'h2_0000, 1);                  // R5 order: range before access
        load(d0_of(12'h001, 3, 2, 1), 32'h0000_FFFF, 32'h0800_0000);
        req(32'h10, 0);
        req(32'h10, 1);
        load(d0_of(0, 2, 3, 1), 32'h0000_FFFF, 32'h0);
        req(32'h0, 1);
        req(32'h0, 0);
        // R5: tiled and non-linear windows win over range and access
        load(d0_of(0, 1, 1, 1), 32'h0000_00FF, 32'h0);
        req(32'h1000, 1);
        load(d0_of(0, 0, 0, 0), 32'h0000_00FF, 32'h0);
        req(32'h10, 0);
        // R2: address wraps past the top
        load(d0_of(12'hFFF, 0, 0, 1), 32'hFFFF_FFFF, 32'hFFFF_F000);
        req(32'h2, 0);
        // R6: load and request in the same cycle
        desc_load = 1; desc_word0 = d0_of(0, 0, 0, 1); desc_word1 = 32'hF; desc_word2 = 32'h0000_4000;
        req_valid = 1; req_offset = 32'h5; req_write = 0;
        tick;
        desc_load = 0;
        tick;                                // held request now accepted under new window
        req_valid = 0;
        tick;

        // R7: classes and access modes
        bld(12'h03D, 0, 0, 32'h1000, 32'h100);
        bld(12'h002, 1, 0, 32'h1000, 32'h100);
        bld(12'h003, 2, 0, 32'h1000, 32'h100);
        bld(12'h004, 0, 0, 32'h1000, 32'h100);
        bld(12'h03D, 3, 0, 32'h1000, 32'h100);
        bld(12'h0FF, 0, 2, 32'h1000, 32'h100);    // class fault wins over target
        // R8: targets
        bld(12'h03D, 0, 1, 32'h0, 32'h10);
        bld(12'h03D, 0, 2, 32'h0, 32'h10);
        bld(12'h03D, 3, 1, 32'h0, 32'h10);
        // R9: range edges
        bld(12'h03D, 0, 0, 32'h00FF_FF00, 32'h100);
        bld(12'h03D, 0, 0, 32'h00FF_FF00, 32'h101);
        bld(12'h03D, 0, 0, 32'h0100_0001, 32'h0);
        bld(12'h03D, 0, 3, 32'h003F_FFF0, 32'h20);
        vram_limit = 32'hFFFF_FFFF;
        bld(12'h03D, 0, 0, 32'hFFFF_FFF0, 32'h20);
        bld(12'h03D, 0, 0, 32'hFFFF_FFF0, 32'h10);
        vram_limit = 32'h0100_0000;
        // R11: aperture base added before split
        bld(12'h002, 1, 3, 32'h0001_2345, 32'h1000);
        agp_base = 32'hFFFF_F800;
        bld(12'h003, 2, 3, 32'h0000_1000, 32'h10);
        agp_base = 32'hE000_0000;
        tick;

        // Randomised mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0)
                load(d0_of($urandom_range(0, 4095), $urandom_range(0, 3), $urandom_range(0, 3),
                           $urandom_range(0, 4) != 0),
                     $urandom_range(0, 32'h3FFF), $urandom());
            req_valid  = $urandom_range(0, 2) != 0;
            req_offset = $urandom_range(0, 32'h4FFF);
            req_write  = $urandom_range(0, 1);
            bld_valid  = $urandom_range(0, 1);
            bld_class  = ($urandom_range(0, 3) == 0) ? 12'($urandom()) : 12'h003;
            bld_access = $urandom_range(0, 3);
            bld_target = $urandom_range(0, 3);
            bld_offset = $urandom_range(0, 32'h0100_0000);
            bld_size   = $urandom_range(0, 32'h0080_0000);
            tick;
            req_valid = 0; bld_valid = 0;
        end
        repeat (3) tick;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule